// File: doc/BRIEF.md
# Bridge Reset Release Sequencer

This block drives the two active-low resets of a bus bridge. One reset covers the data-path master and slave ports. The other covers the control-register port. A static mode pin selects which status flag allows release. In endpoint mode the flag is the function's active-power-state indication. In root port mode it is the physical layer's ready flag, and the link state plays no part. The status flags pass through a two-flop synchroniser. After the selected flag has been high for a parameterised number of extra cycles, both resets release on a clock edge.

Three sources force both resets low at once, without waiting for a clock edge: the board connector reset (active low), the upstream user reset (active high) and a user-driven soft reset (active low). When a forcing source is removed, the release sequence starts again from the beginning. If the release flag drops while the resets are released, both resets assert again.

A synchronised copy of the link-up flag is cleared only by the connector reset, so a soft reset leaves it unchanged. A pulse-width counter watches the soft reset and raises a one-cycle warning when a pulse ends before the minimum low time. That minimum is given in clock cycles and stands for the completion timeout.

Top module: `brg_rst_seq`

## Requirements
- R1: With `mode_rp`=0 (endpoint), both resets stay low while `fn_active` is low, whatever the state of `phy_ready` and `link_up`.
- R2: With `mode_rp`=1 (root port), `phy_ready` alone releases both resets. `link_up` and `fn_active` have no effect.
- R3: `dp_rst_n` and `ctl_rst_n` are equal in every cycle.
- R4: Suppose every forcing source is inactive and the selected release flag rises just before clock edge 1. Both resets then go high after rising edge HOLD_CYC+2 and stay low through edge HOLD_CYC+1. HOLD_CYC must be at least 1.
- R5: Suppose the selected flag falls while the resets are high, just before edge 1. The resets stay high after edge 2 and are low after edge 3.
- R6: `conn_rst_n`=0 or `up_rst`=1 pulls both resets low in the same cycle, without waiting for a clock edge. When the source is removed, the full R4 latency applies again, counted from the first edge at which the source is inactive.
- R7: `soft_rst_n`=0 pulls both resets low in the same cycle and leaves `link_up_o` unchanged. After `soft_rst_n` returns high, release follows the R4 latency.
- R8: With `soft_rst_n` tied high from time zero, the resets release normally under R1, R2 and R4.
- R9: Let N be the number of rising edges at which `soft_rst_n` was sampled low before it returned high. If N < SOFT_MIN_CYC, `soft_short` is high for exactly one cycle after the first edge that samples `soft_rst_n` high again. If N >= SOFT_MIN_CYC, `soft_short` stays low.
- R10: `link_up_o` follows `link_up` with a delay of two rising edges. The connector reset clears it on the next edge. Neither the upstream reset nor the soft reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| conn_rst_n | input | 1 | Board connector reset, active low |
| up_rst | input | 1 | Upstream user reset, active high |
| soft_rst_n | input | 1 | User soft reset, active low; tie high if unused |
| mode_rp | input | 1 | 0 = endpoint, 1 = root port (static) |
| phy_ready | input | 1 | Physical layer ready flag |
| link_up | input | 1 | Link-up flag |
| fn_active | input | 1 | Function in active, configured and enabled power state |
| dp_rst_n | output | 1 | Data-path port reset, active low |
| ctl_rst_n | output | 1 | Control-register port reset, active low |
| link_up_o | output | 1 | Synchronised link-up flag, unaffected by soft reset |
| soft_short | output | 1 | One-cycle warning that a soft reset pulse was too short |

## Verification
The bench drives a table of mode and flag combinations and checks the resets. This table catches a design that reads the wrong flag in a mode, or one that lets the link state gate release in root port mode. The bench counts the release latency to the exact edge after a flag rise, after an upstream reset and after a soft reset. A missing synchroniser stage or an off-by-one hold counter therefore shows up as release one edge early or one edge late. Forcing sources are checked in the same cycle, which exposes a design that only asserts reset on a clock edge. The pulse checker is tested at SOFT_MIN_CYC-1 and at SOFT_MIN_CYC low cycles. A wrong comparison flags the legal pulse or misses the short one. The link copy is checked during a soft reset, so a design that cleared it there would drop the indication.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic {
        MODE_EP = 1'b0,
        MODE_RP = 1'b1
    } brs_mode_e;

    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_WAIT = 2'd1,
        ST_OPEN = 2'd2
    } brs_rel_st_e;

    // synchronised status that can gate release
    typedef struct packed {
        logic phy_rdy;
        logic fn_act;
    } brs_cond_t;

    localparam int unsigned NUM_RST = 2;
    localparam int unsigned IDX_DP  = 0;
    localparam int unsigned IDX_CTL = 1;

    function automatic logic release_cond(input brs_mode_e mode, input brs_cond_t c);
        return (mode == MODE_RP) ? c.phy_rdy : c.fn_act;
    endfunction

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
    parameter int unsigned W     = 1,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_o = stage[DEPTH-1];

endmodule

// File: rtl/brs_release.sv
module brs_release
    import brs_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic clr_i,
    input  logic cond_i,
    output logic open_o
);
    localparam int unsigned CW = cnt_w(HOLD_CYC);

    brs_rel_st_e st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr_i || !cond_i) begin
            st_q  <= ST_HELD;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_HELD: begin
                    cnt_q <= CW'(1);
                    st_q  <= (HOLD_CYC <= 1) ? ST_OPEN : ST_WAIT;
                end
                ST_WAIT: begin
                    if (cnt_q == CW'(HOLD_CYC - 1)) st_q <= ST_OPEN;
                    else                            cnt_q <= cnt_q + CW'(1);
                end
                ST_OPEN: st_q <= ST_OPEN;
                default: st_q <= ST_HELD;
            endcase
        end
    end

    assign open_o = (st_q == ST_OPEN);

    // R5: a lost condition closes the unit on the next edge
    p_close_on_drop_r5: assert property (@(posedge clk) disable iff (clr_i)
        (open_o && !cond_i) |=> !open_o);

    // R4: the unit never opens straight from the held state
    p_no_skip_r4: assert property (@(posedge clk) disable iff (clr_i)
        $rose(open_o) |-> ($past(st_q) != ST_HELD) || (HOLD_CYC <= 1));

endmodule

// File: rtl/brs_pulse_chk.sv
module brs_pulse_chk
    import brs_pkg::*;
#(
    parameter int unsigned SOFT_MIN_CYC = 5000000
) (
    input  logic clk,
    input  logic clr_i,
    input  logic soft_rst_n,
    output logic short_o
);
    localparam int unsigned CW = cnt_w(SOFT_MIN_CYC);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            low_cnt_q <= '0;
            short_o   <= 1'b0;
        end else begin
            short_o <= 1'b0;
            if (!soft_rst_n) begin
                if (low_cnt_q != CW'(SOFT_MIN_CYC)) low_cnt_q <= low_cnt_q + CW'(1);
            end else begin
                if (low_cnt_q != '0 && low_cnt_q < CW'(SOFT_MIN_CYC)) short_o <= 1'b1;
                low_cnt_q <= '0;
            end
        end
    end

    // R9: the warning is a single-cycle pulse
    p_flag_pulse_r9: assert property (@(posedge clk) disable iff (clr_i)
        short_o |=> !short_o);

    // R9: the warning follows a low-to-high soft reset transition
    p_flag_cause_r9: assert property (@(posedge clk) disable iff (clr_i)
        short_o |-> ($past(soft_rst_n, 1) && !$past(soft_rst_n, 2)));

endmodule

// File: rtl/brg_rst_seq.sv
module brg_rst_seq
    import brs_pkg::*;
#(
    parameter int unsigned HOLD_CYC     = 16,
    parameter int unsigned SOFT_MIN_CYC = 5000000,
    parameter int unsigned SYNC_DEPTH   = 2
) (
    input  logic clk,
    input  logic conn_rst_n,
    input  logic up_rst,
    input  logic soft_rst_n,
    input  logic mode_rp,
    input  logic phy_ready,
    input  logic link_up,
    input  logic fn_active,
    output logic dp_rst_n,
    output logic ctl_rst_n,
    output logic link_up_o,
    output logic soft_short
);
    localparam int unsigned CONDW = $bits(brs_cond_t);
    localparam int unsigned RW    = cnt_w(HOLD_CYC);

    logic      hard_rst;
    logic      force_rst;
    brs_mode_e mode;
    brs_cond_t cond_raw, cond_s;
    logic [CONDW-1:0] cond_q;
    logic      rel_cond;
    logic [NUM_RST-1:0] open_v;
    logic [NUM_RST-1:0] rst_n_v;

    assign hard_rst  = !conn_rst_n;
    assign force_rst = hard_rst || up_rst || !soft_rst_n;
    assign mode      = brs_mode_e'(mode_rp);

    assign cond_raw.phy_rdy = phy_ready;
    assign cond_raw.fn_act  = fn_active;

    brs_sync #(.W(CONDW), .DEPTH(SYNC_DEPTH)) u_cond_sync (
        .clk   (clk),
        .clr_i (force_rst),
        .d_i   (cond_raw),
        .q_o   (cond_q)
    );
    assign cond_s   = brs_cond_t'(cond_q);
    assign rel_cond = release_cond(mode, cond_s);

    brs_sync #(.W(1), .DEPTH(SYNC_DEPTH)) u_link_sync (
        .clk   (clk),
        .clr_i (hard_rst),
        .d_i   (link_up),
        .q_o   (link_up_o)
    );

    for (genvar g = 0; g < NUM_RST; g++) begin : g_rel
        brs_release #(.HOLD_CYC(HOLD_CYC)) u_rel (
            .clk    (clk),
            .clr_i  (force_rst),
            .cond_i (rel_cond),
            .open_o (open_v[g])
        );
        assign rst_n_v[g] = open_v[g] && !force_rst;
    end

    assign dp_rst_n  = rst_n_v[IDX_DP];
    assign ctl_rst_n = rst_n_v[IDX_CTL];

    brs_pulse_chk #(.SOFT_MIN_CYC(SOFT_MIN_CYC)) u_pulse (
        .clk        (clk),
        .clr_i      (hard_rst),
        .soft_rst_n (soft_rst_n),
        .short_o    (soft_short)
    );

    // run length of an uninterrupted release condition, for the hold check
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (force_rst || !rel_cond) run_q <= '0;
        else if (run_q != RW'(HOLD_CYC)) run_q <= run_q + RW'(1);
    end

    // R3: both outputs agree
    p_same_r3: assert property (@(posedge clk) disable iff (hard_rst)
        dp_rst_n == ctl_rst_n);

    // R4: release only after the full hold window
    p_hold_r4: assert property (@(posedge clk) disable iff (hard_rst)
        $rose(dp_rst_n) |-> (run_q >= RW'(HOLD_CYC)));

    // R6: a forcing source seen on an edge keeps the outputs low after it
    p_force_r6: assert property (@(posedge clk) disable iff (hard_rst)
        force_rst |=> (!dp_rst_n && !ctl_rst_n));

    // R1: endpoint mode waits for the power-state flag
    p_ep_gate_r1: assert property (@(posedge clk) disable iff (hard_rst)
        (mode == MODE_EP && !cond_s.fn_act) |=> !dp_rst_n);

    // R2: root port mode waits for the physical layer only
    p_rp_gate_r2: assert property (@(posedge clk) disable iff (hard_rst)
        (mode == MODE_RP && !cond_s.phy_rdy) |=> !dp_rst_n);

endmodule

// File: tb/sim_brg_rst_seq.sv
module sim_brg_rst_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 16;
    localparam int SMIN       = 40;

    logic clk = 1'b0;
    logic conn_rst_n, up_rst, soft_rst_n, mode_rp, phy_ready, link_up, fn_active;
    logic dp_rst_n, ctl_rst_n, link_up_o, soft_short;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brg_rst_seq #(.HOLD_CYC(HOLD), .SOFT_MIN_CYC(SMIN)) u0 (
        .clk(clk), .conn_rst_n(conn_rst_n), .up_rst(up_rst), .soft_rst_n(soft_rst_n),
        .mode_rp(mode_rp), .phy_ready(phy_ready), .link_up(link_up), .fn_active(fn_active),
        .dp_rst_n(dp_rst_n), .ctl_rst_n(ctl_rst_n), .link_up_o(link_up_o),
        .soft_short(soft_short)
    );

    // fields: [4] mode_rp, [3] phy_ready, [2] link_up, [1] fn_active, [0] expected release
    localparam logic [4:0] VEC [8] = '{
        5'b0_000_0, 5'b0_110_0, 5'b0_001_1, 5'b0_111_1,
        5'b1_100_1, 5'b1_011_0, 5'b1_110_1, 5'b1_000_0
    };

    task automatic edges(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_rst(input string tag, input logic exp);
        chk(tag, dp_rst_n, exp);
        chk({tag, " ctl"}, ctl_rst_n, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        conn_rst_n = 1'b0; up_rst = 1'b0; soft_rst_n = 1'b1;
        mode_rp = 1'b0; phy_ready = 1'b0; link_up = 1'b0; fn_active = 1'b0;
        @(negedge clk);
        edges(3);
        chk_rst("R6 reset state", 1'b0);
        chk("R10 reset link", link_up_o, 1'b0);
        chk("R9 reset flag", soft_short, 1'b0);
        conn_rst_n = 1'b1;

        // table walk: R1, R2, R8 (soft reset tied high)
        for (int i = 0; i < 8; i++) begin
            up_rst = 1'b1;
            {mode_rp, phy_ready, link_up, fn_active} = VEC[i][4:1];
            edges(2);
            up_rst = 1'b0;
            edges(HOLD + 4);
            chk_rst(VEC[i][4] ? "R2 root vector" : "R1 endpoint vector", VEC[i][0]);
        end

        // R4 exact latency in root port mode
        up_rst = 1'b1; mode_rp = 1'b1; phy_ready = 1'b0; link_up = 1'b0; fn_active = 1'b0;
        edges(2);
        up_rst = 1'b0;
        edges(3);
        chk_rst("R4 idle", 1'b0);
        phy_ready = 1'b1;
        edges(HOLD + 1);
        chk_rst("R4 before", 1'b0);
        edges(1);
        chk_rst("R4 release R8", 1'b1);

        // R5 condition drop
        phy_ready = 1'b0;
        edges(2);
        chk_rst("R5 still open", 1'b1);
        edges(1);
        chk_rst("R5 closed", 1'b0);
        phy_ready = 1'b1;
        edges(HOLD + 4);
        chk_rst("R5 reopen", 1'b1);

        // R6 upstream reset
        up_rst = 1'b1;
        #1;
        chk_rst("R6 upstream immediate", 1'b0);
        edges(1);
        up_rst = 1'b0;
        edges(HOLD + 1);
        chk_rst("R6 upstream before", 1'b0);
        edges(1);
        chk_rst("R6 upstream release", 1'b1);

        // R6 connector reset
        conn_rst_n = 1'b0;
        #1;
        chk_rst("R6 connector immediate", 1'b0);
        edges(2);
        conn_rst_n = 1'b1;
        edges(HOLD + 4);
        chk_rst("R6 connector release", 1'b1);

        // R10 link copy latency
        link_up = 1'b1;
        edges(1);
        chk("R10 link edge1", link_up_o, 1'b0);
        edges(1);
        chk("R10 link edge2", link_up_o, 1'b1);

        // R7 soft reset, legal length; R9 boundary at SMIN
        soft_rst_n = 1'b0;
        #1;
        chk_rst("R7 soft immediate", 1'b0);
        chk("R7 link kept", link_up_o, 1'b1);
        edges(SMIN);
        chk("R7 link kept long", link_up_o, 1'b1);
        chk_rst("R7 soft held", 1'b0);
        soft_rst_n = 1'b1;
        edges(1);
        chk("R9 no flag at minimum", soft_short, 1'b0);
        edges(HOLD);
        chk_rst("R7 soft before", 1'b0);
        edges(1);
        chk_rst("R7 soft release", 1'b1);

        // R9 short pulses
        soft_rst_n = 1'b0;
        edges(SMIN - 1);
        soft_rst_n = 1'b1;
        edges(1);
        chk("R9 flag just short", soft_short, 1'b1);
        edges(1);
        chk("R9 flag one cycle", soft_short, 1'b0);
        soft_rst_n = 1'b0;
        edges(1);
        soft_rst_n = 1'b1;
        edges(1);
        chk("R9 flag single cycle low", soft_short, 1'b1);
        chk("R7 link after soft", link_up_o, 1'b1);

        // R10 clearing: upstream reset keeps it, connector reset clears it
        up_rst = 1'b1;
        edges(2);
        chk("R10 upstream keeps link", link_up_o, 1'b1);
        up_rst = 1'b0;
        conn_rst_n = 1'b0;
        edges(1);
        chk("R10 connector clears link", link_up_o, 1'b0);
        conn_rst_n = 1'b1;
        edges(2);
        chk("R10 link back", link_up_o, 1'b1);
        link_up = 1'b0;
        edges(1);
        chk("R10 fall edge1", link_up_o, 1'b1);
        edges(1);
        chk("R10 fall edge2", link_up_o, 1'b0);

        finish_run();
    end

endmodule